// File: doc/BRIEF.md
# Multi-Ratio System Clock Divider

This block runs entirely on one master clock of roughly 24 MHz. From it, it produces a fixed family of slower timing levels. Three come from a binary chain that divides by 2, 4 and 8. Two come from a modulo-3 chain that divides by 3 and by 6. The divide-by-3 level is deliberately asymmetric: it is high for one master cycle and low for two. The divide-by-6 level is symmetric. Its rising edges line up with every other rising edge of the divide-by-3 level. The half-rate level is also offered as a separate true/complement pair for a processor. The divide-by-4 and divide-by-6 levels each come with an inverted copy.

Every output is the direct output of a flip-flop clocked by the master clock, so none of them glitches. Each rate also has a one-cycle strobe, which is high during the master cycle just before that rate's rising edge. Logic clocked by the master clock can use the strobe as a clock enable instead of clocking on a derived level. The logic counts master cycles only and has no notion of frequency, so it behaves the same at the nominal rate and at a slightly faster variant near 24.17 MHz.

A synchronous reset parks all outputs in a known state. On release, every derived level starts from the same phase.

Top module: `sysclk_divider`

## Requirements
- R1: While `rst` is sampled high at a master edge, after that edge all true-polarity outputs are 0, the inverted outputs (`div4_no`, `div6_no`, `cpu_clk_no`) are 1, and every strobe is 0.
- R2: At the first master edge at which `rst` is sampled low after being high, all true-polarity outputs rise together and all inverted outputs fall together.
- R3: `div2_o` has a period of 2 master cycles and is high for 1. `cpu_clk_o` always equals `div2_o`, and `cpu_clk_no` is always its complement.
- R4: `div4_o` has a period of 4 master cycles and is high for 2. `div4_no` is always its complement.
- R5: `div8_o` has a period of 8 master cycles and is high for 4.
- R6: `div3_o` has a period of 3 master cycles and is high for exactly 1 of them, then low for 2.
- R7: `div6_o` has a period of 6 master cycles and is high for 3. `div6_no` is always its complement. Each rise of `div6_o` coincides with a rise of `div3_o`, on every second `div3_o` rise, starting with the first one after reset.
- R8: Each strobe (`stb2`, `stb4`, `stb8`, `stb3`, `stb6`) is 1 in exactly those master cycles whose closing edge makes the matching output rise, and 0 otherwise.
- R9: Asserting `rst` in the middle of operation, for any number of cycles, brings all outputs back to the R1 state. The next release restarts every output at the R2 phase, whatever phase the outputs had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock, about 24 MHz |
| rst | input | 1 | Synchronous reset, active high |
| div2_o | output | 1 | Master divided by 2 |
| cpu_clk_o | output | 1 | Processor clock, true, divided by 2 |
| cpu_clk_no | output | 1 | Processor clock, complement |
| div4_o | output | 1 | Master divided by 4 |
| div4_no | output | 1 | Inverted divide-by-4 |
| div8_o | output | 1 | Master divided by 8 |
| div3_o | output | 1 | Master divided by 3, one-third high |
| div6_o | output | 1 | Master divided by 6 |
| div6_no | output | 1 | Inverted divide-by-6 |
| stb2 | output | 1 | Strobe before each rise of div2_o |
| stb4 | output | 1 | Strobe before each rise of div4_o |
| stb8 | output | 1 | Strobe before each rise of div8_o |
| stb3 | output | 1 | Strobe before each rise of div3_o |
| stb6 | output | 1 | Strobe before each rise of div6_o |

## Verification
The bench drives the divider with reset pulses of different lengths and run lengths of different sizes. One run of 48 cycles is a multiple of both 6 and 8. One run of 37 cycles is a multiple of neither, so the next reset hits both chains at an odd phase; if the reset left a phase stale, the next run shows it. A short two-cycle reset between runs separates a true synchronous restart from any dependence on how long reset is held. Over every run, each cycle's levels and strobes are compared against a model that computes them from the cycle count since release. That comparison separates period, high time and the alignment of the two chains.

// File: rtl/sysclk_divider.sv
module sysclk_divider (
  input  logic clk_m,
  input  logic rst,
  output logic div2_o,
  output logic cpu_clk_o,
  output logic cpu_clk_no,
  output logic div4_o,
  output logic div4_no,
  output logic div8_o,
  output logic div3_o,
  output logic div6_o,
  output logic div6_no,
  output logic stb2,
  output logic stb4,
  output logic stb8,
  output logic stb3,
  output logic stb6
);

  logic [2:0] bin_q;
  logic [1:0] tri_q;
  logic       six_q;

  logic lead2, lead4, lead8, lead3, lead6;

  assign lead2 = (bin_q[0] == 1'b0);
  assign lead4 = (bin_q[1:0] == 2'd0);
  assign lead8 = (bin_q == 3'd0);
  assign lead3 = (tri_q == 2'd0);
  assign lead6 = lead3 && !six_q;

  always_ff @(posedge clk_m) begin
    if (rst) begin
      bin_q <= 3'd0;
      tri_q <= 2'd0;
      six_q <= 1'b0;
    end else begin
      bin_q <= bin_q + 3'd1;
      tri_q <= (tri_q == 2'd2) ? 2'd0 : tri_q + 2'd1;
      if (tri_q == 2'd2)
        six_q <= !six_q;
    end
  end

  always_ff @(posedge clk_m) begin
    if (rst) begin
      div2_o     <= 1'b0;
      cpu_clk_o  <= 1'b0;
      cpu_clk_no <= 1'b1;
      div4_o     <= 1'b0;
      div4_no    <= 1'b1;
      div8_o     <= 1'b0;
      div3_o     <= 1'b0;
      div6_o     <= 1'b0;
      div6_no    <= 1'b1;
    end else begin
      div2_o     <= lead2;
      cpu_clk_o  <= lead2;
      cpu_clk_no <= !lead2;
      div4_o     <= !bin_q[1];
      div4_no    <= bin_q[1];
      div8_o     <= !bin_q[2];
      div3_o     <= lead3;
      div6_o     <= !six_q;
      div6_no    <= six_q;
    end
  end

  assign stb2 = !rst && lead2;
  assign stb4 = !rst && lead4;
  assign stb8 = !rst && lead8;
  assign stb3 = !rst && lead3;
  assign stb6 = !rst && lead6;

endmodule

// File: rtl/sysclk_divider_props.sv
module sysclk_divider_props (
  input logic clk_m,
  input logic rst,
  input logic div2_o,
  input logic cpu_clk_o,
  input logic cpu_clk_no,
  input logic div4_o,
  input logic div4_no,
  input logic div8_o,
  input logic div3_o,
  input logic div6_o,
  input logic div6_no,
  input logic stb2,
  input logic stb4,
  input logic stb8,
  input logic stb3,
  input logic stb6
);

  logic was_rst;
  logic seen;

  always_ff @(posedge clk_m) begin
    was_rst <= rst;
    seen    <= 1'b1;
  end

  always_ff @(posedge clk_m) begin
    if (seen === 1'b1 && was_rst === 1'b1)
      p_reset_levels_r1: assert (!div2_o && !cpu_clk_o && cpu_clk_no && !div4_o && div4_no &&
                                 !div8_o && !div3_o && !div6_o && div6_no)
        else $error("reset levels wrong");
  end

  p_first_rise_r2: assert property (@(posedge clk_m) disable iff (rst)
    was_rst |=> (div2_o && cpu_clk_o && div4_o && div8_o && div3_o && div6_o &&
                 !cpu_clk_no && !div4_no && !div6_no));

  p_cpu_pair_r3: assert property (@(posedge clk_m) disable iff (rst)
    (cpu_clk_o == div2_o) && (cpu_clk_no == !div2_o));

  p_div4_inv_r4: assert property (@(posedge clk_m) disable iff (rst)
    div4_no == !div4_o);

  p_div3_shape_r6: assert property (@(posedge clk_m) disable iff (rst)
    div3_o |=> !div3_o ##1 !div3_o);

  p_div6_inv_r7: assert property (@(posedge clk_m) disable iff (rst)
    div6_no == !div6_o);

  p_div6_on_div3_r7: assert property (@(posedge clk_m) disable iff (rst)
    stb6 |-> stb3);

  p_stb2_rise_r8: assert property (@(posedge clk_m) disable iff (rst)
    stb2 |=> (div2_o && !$past(div2_o)));

  p_stb3_rise_r8: assert property (@(posedge clk_m) disable iff (rst)
    stb3 |=> (div3_o && !$past(div3_o)));

  p_stb6_only_r8: assert property (@(posedge clk_m) disable iff (rst)
    !stb6 |=> !(div6_o && !$past(div6_o)));

  p_stb8_only_r8: assert property (@(posedge clk_m) disable iff (rst)
    !stb8 |=> !(div8_o && !$past(div8_o)));

endmodule

bind sysclk_divider sysclk_divider_props i_props (.*);

// File: tb/test_sysclk_divider.sv
module test_sysclk_divider;

  logic clk_m = 1'b0;
  logic rst   = 1'b1;
  logic div2_o, cpu_clk_o, cpu_clk_no, div4_o, div4_no, div8_o;
  logic div3_o, div6_o, div6_no;
  logic stb2, stb4, stb8, stb3, stb6;

  always #10 clk_m = !clk_m;

  sysclk_divider i_sysclk_divider (
    .clk_m(clk_m), .rst(rst),
    .div2_o(div2_o), .cpu_clk_o(cpu_clk_o), .cpu_clk_no(cpu_clk_no),
    .div4_o(div4_o), .div4_no(div4_no), .div8_o(div8_o),
    .div3_o(div3_o), .div6_o(div6_o), .div6_no(div6_no),
    .stb2(stb2), .stb4(stb4), .stb8(stb8), .stb3(stb3), .stb6(stb6)
  );

  typedef struct packed {
    logic in_rst, first;
    logic d2, d4, d8, d3, d6;
    logic s2, s4, s8, s3, s6;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_m); #1;
      q.push_back('{in_rst:1'b1, first:1'b0, d2:0, d4:0, d8:0, d3:0, d6:0,
                    s2:0, s4:0, s8:0, s3:0, s6:0});
    end
    @(negedge clk_m); #2;
    rst = 1'b0;
  endtask

  task automatic push_run(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_m); #1;
      q.push_back('{in_rst:1'b0, first:(k == 0),
                    d2:(k % 2 == 0), d4:(k % 4 < 2), d8:(k % 8 < 4),
                    d3:(k % 3 == 0), d6:(k % 6 < 3),
                    s2:((k + 1) % 2 == 0), s4:((k + 1) % 4 == 0), s8:((k + 1) % 8 == 0),
                    s3:((k + 1) % 3 == 0), s6:((k + 1) % 6 == 0)});
    end
    @(negedge clk_m); #2;
  endtask

  always @(negedge clk_m) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.in_rst) begin
        chk("R1/R9 div2", div2_o, 1'b0);
        chk("R1/R9 cpu_n", cpu_clk_no, 1'b1);
        chk("R1/R9 div4_n", div4_no, 1'b1);
        chk("R1/R9 div6_n", div6_no, 1'b1);
        chk("R1/R9 div8", div8_o, 1'b0);
        chk("R1/R9 div3", div3_o, 1'b0);
        chk("R1 strobes", stb2 | stb4 | stb8 | stb3 | stb6, 1'b0);
      end else begin
        if (e.first)
          chk("R2 all rise", div2_o & div4_o & div8_o & div3_o & div6_o & cpu_clk_o
                             & !div4_no & !div6_no & !cpu_clk_no, 1'b1);
        chk("R3 div2", div2_o, e.d2);
        chk("R3 cpu", cpu_clk_o, e.d2);
        chk("R3 cpu_n", cpu_clk_no, !e.d2);
        chk("R4 div4", div4_o, e.d4);
        chk("R4 div4_n", div4_no, !e.d4);
        chk("R5 div8", div8_o, e.d8);
        chk("R6 div3", div3_o, e.d3);
        chk("R7 div6", div6_o, e.d6);
        chk("R7 div6_n", div6_no, !e.d6);
        chk("R8 stb2", stb2, e.s2);
        chk("R8 stb4", stb4, e.s4);
        chk("R8 stb8", stb8, e.s8);
        chk("R8 stb3", stb3, e.s3);
        chk("R8 stb6", stb6, e.s6);
      end
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    push_reset(4);
    push_run(48);
    push_reset(3);   // R9 mid-run reset after a full cycle
    push_run(37);
    push_reset(2);   // R9 reset at an odd phase of both chains
    push_run(50);
    push_reset(1);
    push_run(13);
    @(negedge clk_m); #3;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule